// File: doc/BRIEF.md
# Programmed I/O Flag and Interrupt Enable Unit

This block is the programmed-I/O corner of a small accumulator machine. It keeps one byte received from an input device and one byte to be sent to an output device, a ready flag for each direction, and the interrupt enable flip-flop. Devices raise the flags through single-cycle strobes. The CPU lowers the flags and moves the bytes by executing I/O instructions, and it tests the flags by executing skip instructions.

The CPU presents the current instruction word together with an execute strobe for one cycle. The unit answers in the same cycle with a skip request and an accumulator low-byte load strobe. The register and flag updates take effect at the next clock edge. The interrupt sequencer pulses a separate input when its last step completes, and this disables interrupts. The unit raises an interrupt request whenever interrupts are enabled and either device needs service.

Top module: `ioflag_unit`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, interrupt enable is 0, and both byte registers are 0.
- R2: A cycle with `devInValid` high and the input flag low loads `devInByte` into the input byte register and sets the input flag at the next edge. This does not happen if an input-transfer instruction executes in that same cycle.
- R3: A `devInValid` strobe while the input flag is 1 is ignored. The input byte and the flag keep their values.
- R4: An instruction is an I/O instruction only when `exeValid` is high, bit 15 is 1 and bits 14:12 equal 7. An I/O instruction with bit 11 set drives `acLoadLow` high in the same cycle, with `inByte` holding the buffered byte, and it clears the input flag at the next edge.
- R5: An I/O instruction with bit 10 set loads `acLow` into the output byte register and clears the output flag at the next edge. It takes priority over a `devOutAck` in the same cycle.
- R6: `devOutAck` sets the output flag at the next edge when the flag is 0. When the flag is already 1 it has no effect.
- R7: In the same cycle, `skipReq` is high exactly when an I/O instruction has bit 9 set and the input flag is 1, or has bit 8 set and the output flag is 1.
- R8: An I/O instruction with bit 7 set enables interrupts, and one with bit 6 set disables them. If both bits are set, disable wins.
- R9: `intTaken` clears interrupt enable at the next edge and overrides a simultaneous enable.
- R10: `intReq` equals interrupt enable AND (input flag OR output flag).
- R11: A word that is not an I/O instruction has no effect on any flag, byte register or same-cycle output. This covers bit 15 = 0, an opcode other than 7, and `exeValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devInValid | input | 1 | Input device byte strobe |
| devInByte | input | 8 | Byte from input device |
| devOutAck | input | 1 | Output device took the byte |
| outByte | output | 8 | Byte presented to output device |
| exeValid | input | 1 | Instruction executes this cycle |
| instrWord | input | 16 | Current instruction word |
| acLow | input | 8 | Accumulator bits 7:0 |
| intTaken | input | 1 | Interrupt cycle finished its last step |
| inByte | output | 8 | Buffered input byte for accumulator low byte |
| acLoadLow | output | 1 | Load accumulator low byte from inByte |
| skipReq | output | 1 | Request PC increment |
| fgiFlag | output | 1 | Input flag |
| fgoFlag | output | 1 | Output flag |
| ienFlag | output | 1 | Interrupt enable |
| intReq | output | 1 | Interrupt request |

## Verification
The properties assume that every input is synchronous to `clk` and has a known level at each edge. They also assume that device strobes and `intTaken` are single-cycle events. No ordering between device events and instruction execution is assumed, so collisions such as a strobe during an input transfer, or an acknowledge during an output transfer, are legal and get checked. The stimulus changes inputs only on the falling edge. It mixes directed collisions with pseudo-random instruction words that are biased toward the I/O opcode, so every combination of instruction bits 11 to 6 appears together with device activity.

// File: rtl/ioflag_pkg.sv
package ioflag_pkg;
  typedef struct packed {
    logic captureIn;
    logic clearIn;
    logic loadOut;
    logic ackOut;
    logic setIen;
    logic clearIen;
  } ioStrobes_t;
endpackage

// File: rtl/ioflag_ctrl.sv
module ioflag_ctrl
  import ioflag_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int IND_BIT = 15,
  parameter int OPC_MSB = 14,
  parameter int OPC_LSB = 12,
  parameter int IO_OPC  = 7,
  parameter int BIT_INP = 11,
  parameter int BIT_OUT = 10,
  parameter int BIT_SKI = 9,
  parameter int BIT_SKO = 8,
  parameter int BIT_ION = 7,
  parameter int BIT_IOF = 6
) (
  input  logic              exeValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              devInValid,
  input  logic              devOutAck,
  input  logic              intTaken,
  input  logic              fgi,
  input  logic              fgo,
  output ioStrobes_t        strobes,
  output logic              skipReq,
  output logic              acLoadLow
);
  localparam int OPC_W = OPC_MSB - OPC_LSB + 1;

  logic ioHit, inpHit, outHit, skiHit, skoHit, ionHit, iofHit;

  always_comb begin
    ioHit  = exeValid && instrWord[IND_BIT] &&
             (instrWord[OPC_MSB:OPC_LSB] == OPC_W'(IO_OPC));
    inpHit = ioHit && instrWord[BIT_INP];
    outHit = ioHit && instrWord[BIT_OUT];
    skiHit = ioHit && instrWord[BIT_SKI];
    skoHit = ioHit && instrWord[BIT_SKO];
    ionHit = ioHit && instrWord[BIT_ION];
    iofHit = ioHit && instrWord[BIT_IOF];

    strobes.clearIn   = inpHit;
    strobes.captureIn = devInValid && !fgi && !inpHit;
    strobes.loadOut   = outHit;
    strobes.ackOut    = devOutAck && !fgo && !outHit;
    strobes.clearIen  = iofHit || intTaken;
    strobes.setIen    = ionHit && !strobes.clearIen;

    skipReq   = (skiHit && fgi) || (skoHit && fgo);
    acLoadLow = inpHit;
  end
endmodule

// File: rtl/ioflag_regs.sv
module ioflag_regs
  import ioflag_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strobes,
  input  logic [BYTE_W-1:0] devInByte,
  input  logic [BYTE_W-1:0] acLow,
  output logic [BYTE_W-1:0] inpr,
  output logic [BYTE_W-1:0] outr,
  output logic              fgi,
  output logic              fgo,
  output logic              ien
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inpr <= '0;
      outr <= '0;
      fgi  <= 1'b0;
      fgo  <= 1'b1;
      ien  <= 1'b0;
    end else begin
      if (strobes.captureIn) inpr <= devInByte;
      if (strobes.loadOut)   outr <= acLow;

      if (strobes.clearIn)        fgi <= 1'b0;
      else if (strobes.captureIn) fgi <= 1'b1;

      if (strobes.loadOut)     fgo <= 1'b0;
      else if (strobes.ackOut) fgo <= 1'b1;

      if (strobes.clearIen)    ien <= 1'b0;
      else if (strobes.setIen) ien <= 1'b1;
    end
  end
endmodule

// File: rtl/ioflag_unit.sv
module ioflag_unit
  import ioflag_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int IND_BIT = 15,
  parameter int OPC_MSB = 14,
  parameter int OPC_LSB = 12,
  parameter int IO_OPC  = 7,
  parameter int BIT_INP = 11,
  parameter int BIT_OUT = 10,
  parameter int BIT_SKI = 9,
  parameter int BIT_SKO = 8,
  parameter int BIT_ION = 7,
  parameter int BIT_IOF = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devInValid,
  input  logic [BYTE_W-1:0] devInByte,
  input  logic              devOutAck,
  output logic [BYTE_W-1:0] outByte,
  input  logic              exeValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [BYTE_W-1:0] acLow,
  input  logic              intTaken,
  output logic [BYTE_W-1:0] inByte,
  output logic              acLoadLow,
  output logic              skipReq,
  output logic              fgiFlag,
  output logic              fgoFlag,
  output logic              ienFlag,
  output logic              intReq
);
  ioStrobes_t strobes;

  ioflag_ctrl #(
    .WORD_W(WORD_W), .IND_BIT(IND_BIT), .OPC_MSB(OPC_MSB), .OPC_LSB(OPC_LSB),
    .IO_OPC(IO_OPC), .BIT_INP(BIT_INP), .BIT_OUT(BIT_OUT), .BIT_SKI(BIT_SKI),
    .BIT_SKO(BIT_SKO), .BIT_ION(BIT_ION), .BIT_IOF(BIT_IOF)
  ) u_ctrl (
    .exeValid  (exeValid),
    .instrWord (instrWord),
    .devInValid(devInValid),
    .devOutAck (devOutAck),
    .intTaken  (intTaken),
    .fgi       (fgiFlag),
    .fgo       (fgoFlag),
    .strobes   (strobes),
    .skipReq   (skipReq),
    .acLoadLow (acLoadLow)
  );

  ioflag_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .devInByte(devInByte),
    .acLow    (acLow),
    .inpr     (inByte),
    .outr     (outByte),
    .fgi      (fgiFlag),
    .fgo      (fgoFlag),
    .ien      (ienFlag)
  );

  assign intReq = ienFlag && (fgiFlag || fgoFlag);
endmodule

// File: rtl/ioflag_unit_chk.sv
module ioflag_unit_chk #(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int IND_BIT = 15,
  parameter int OPC_MSB = 14,
  parameter int OPC_LSB = 12,
  parameter int IO_OPC  = 7,
  parameter int BIT_INP = 11,
  parameter int BIT_OUT = 10,
  parameter int BIT_SKI = 9,
  parameter int BIT_SKO = 8,
  parameter int BIT_ION = 7,
  parameter int BIT_IOF = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              devInValid,
  input logic [BYTE_W-1:0] devInByte,
  input logic              devOutAck,
  input logic [BYTE_W-1:0] outByte,
  input logic              exeValid,
  input logic [WORD_W-1:0] instrWord,
  input logic [BYTE_W-1:0] acLow,
  input logic              intTaken,
  input logic [BYTE_W-1:0] inByte,
  input logic              acLoadLow,
  input logic              skipReq,
  input logic              fgiFlag,
  input logic              fgoFlag,
  input logic              ienFlag,
  input logic              intReq
);
  localparam int OPC_W = OPC_MSB - OPC_LSB + 1;

  logic isIo;
  assign isIo = exeValid && instrWord[IND_BIT] &&
                (instrWord[OPC_MSB:OPC_LSB] == OPC_W'(IO_OPC));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (devInValid && !fgiFlag && !(isIo && instrWord[BIT_INP]))
      |=> (fgiFlag && inByte == $past(devInByte)));

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (devInValid && fgiFlag && !(isIo && instrWord[BIT_INP]))
      |=> (fgiFlag && $stable(inByte)));

  p_inp_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isIo && instrWord[BIT_INP]) |=> !fgiFlag);

  p_out_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isIo && instrWord[BIT_OUT]) |=> (!fgoFlag && outByte == $past(acLow)));

  p_ack_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (devOutAck && !(isIo && instrWord[BIT_OUT])) |=> fgoFlag);

  p_skip_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> (isIo && (fgiFlag || fgoFlag)));

  p_ion_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isIo && instrWord[BIT_ION] && !instrWord[BIT_IOF] && !intTaken) |=> ienFlag);

  p_int_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |=> !ienFlag);

  p_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (ienFlag && (fgiFlag || fgoFlag)));

  p_nonio_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!isIo && !devInValid && !devOutAck && !intTaken)
      |=> ($stable(fgiFlag) && $stable(fgoFlag) && $stable(ienFlag) &&
           $stable(outByte) && $stable(inByte)));

  p_nonio_comb_r11: assert property (@(posedge clk) disable iff (!rstN)
    !isIo |-> (!skipReq && !acLoadLow));
endmodule

bind ioflag_unit ioflag_unit_chk #(
  .BYTE_W(BYTE_W), .WORD_W(WORD_W), .IND_BIT(IND_BIT), .OPC_MSB(OPC_MSB),
  .OPC_LSB(OPC_LSB), .IO_OPC(IO_OPC), .BIT_INP(BIT_INP), .BIT_OUT(BIT_OUT),
  .BIT_SKI(BIT_SKI), .BIT_SKO(BIT_SKO), .BIT_ION(BIT_ION), .BIT_IOF(BIT_IOF)
) u_chk (
  .clk(clk), .rstN(rstN), .devInValid(devInValid), .devInByte(devInByte),
  .devOutAck(devOutAck), .outByte(outByte), .exeValid(exeValid),
  .instrWord(instrWord), .acLow(acLow), .intTaken(intTaken), .inByte(inByte),
  .acLoadLow(acLoadLow), .skipReq(skipReq), .fgiFlag(fgiFlag),
  .fgoFlag(fgoFlag), .ienFlag(ienFlag), .intReq(intReq)
);

// File: tb/test_ioflag_unit.sv
`timescale 1ns/1ps
module test_ioflag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devInValid = 1'b0;
  logic [7:0]  devInByte = '0;
  logic        devOutAck = 1'b0;
  logic [7:0]  outByte;
  logic        exeValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [7:0]  acLow = '0;
  logic        intTaken = 1'b0;
  logic [7:0]  inByte;
  logic        acLoadLow, skipReq, fgiFlag, fgoFlag, ienFlag, intReq;

  int nChecks = 0;
  int nFails  = 0;

  bit       mFgi = 0, mFgo = 1, mIen = 0;
  bit [7:0] mInpr = 0, mOutr = 0;

  always #4 clk = ~clk;

  ioflag_unit i_ioflag_unit (
    .clk(clk), .rstN(rstN), .devInValid(devInValid), .devInByte(devInByte),
    .devOutAck(devOutAck), .outByte(outByte), .exeValid(exeValid),
    .instrWord(instrWord), .acLow(acLow), .intTaken(intTaken), .inByte(inByte),
    .acLoadLow(acLoadLow), .skipReq(skipReq), .fgiFlag(fgiFlag),
    .fgoFlag(fgoFlag), .ienFlag(ienFlag), .intReq(intReq)
  );

  task automatic cmp(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // One cycle: drive at falling edge, compare, advance the model, cross the edge.
  task automatic step(input bit exe, input logic [15:0] w, input bit inV,
                      input logic [7:0] inB, input bit ack, input logic [7:0] ac,
                      input bit taken, input string tag);
    bit io, eSkip, eLoad;
    exeValid = exe; instrWord = w; devInValid = inV; devInByte = inB;
    devOutAck = ack; acLow = ac; intTaken = taken;
    #1;
    io    = exe && w[15] && (w[14:12] == 3'd7);
    eSkip = io && ((w[9] && mFgi) || (w[8] && mFgo));
    eLoad = io && w[11];
    cmp({"R7 ", tag}, "skipReq", {7'd0, skipReq}, {7'd0, eSkip});
    cmp({"R4 ", tag}, "acLoadLow", {7'd0, acLoadLow}, {7'd0, eLoad});
    cmp({"R2 ", tag}, "fgiFlag", {7'd0, fgiFlag}, {7'd0, mFgi});
    cmp({"R3 ", tag}, "inByte", inByte, mInpr);
    cmp({"R6 ", tag}, "fgoFlag", {7'd0, fgoFlag}, {7'd0, mFgo});
    cmp({"R5 ", tag}, "outByte", outByte, mOutr);
    cmp({"R8 ", tag}, "ienFlag", {7'd0, ienFlag}, {7'd0, mIen});
    cmp({"R10 ", tag}, "intReq", {7'd0, intReq}, {7'd0, mIen && (mFgi || mFgo)});
    if (io && w[11]) mFgi = 0;
    else if (inV && !mFgi) begin mFgi = 1; mInpr = inB; end
    if (io && w[10]) begin mFgo = 0; mOutr = ac; end
    else if (ack && !mFgo) mFgo = 1;
    if (taken || (io && w[6])) mIen = 0;
    else if (io && w[7]) mIen = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] ioWord(input int bitPos);
    return 16'hF000 | (16'd1 << bitPos);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    cmp("R1", "fgiFlag", {7'd0, fgiFlag}, 8'd0);
    cmp("R1", "fgoFlag", {7'd0, fgoFlag}, 8'd1);
    cmp("R1", "ienFlag", {7'd0, ienFlag}, 8'd0);
    cmp("R1", "inByte", inByte, 8'h00);
    cmp("R1", "outByte", outByte, 8'h00);
    @(negedge clk);

    step(0, 16'h0,       1, 8'hA5, 0, 8'h00, 0, "R2 capture");
    step(0, 16'h0,       1, 8'h3C, 0, 8'h00, 0, "R3 busy ignore");
    step(1, ioWord(9),   0, 8'h00, 0, 8'h00, 0, "R7 ski taken");
    step(1, ioWord(11),  0, 8'h00, 0, 8'h00, 0, "R4 inp");
    step(1, ioWord(9),   0, 8'h00, 0, 8'h00, 0, "R7 ski not taken");
    step(1, ioWord(10),  0, 8'h00, 0, 8'h5A, 0, "R5 out");
    step(1, ioWord(8),   0, 8'h00, 0, 8'h00, 0, "R7 sko not taken");
    step(0, 16'h0,       0, 8'h00, 1, 8'h00, 0, "R6 ack");
    step(0, 16'h0,       0, 8'h00, 1, 8'h00, 0, "R6 ack when set");
    step(1, ioWord(8),   0, 8'h00, 0, 8'h00, 0, "R7 sko taken");
    step(1, ioWord(7),   0, 8'h00, 0, 8'h00, 0, "R8 ion");
    step(0, 16'h0,       0, 8'h00, 0, 8'h00, 0, "R10 request");
    step(1, ioWord(7),   0, 8'h00, 0, 8'h00, 1, "R9 taken beats ion");
    step(1, 16'hF0C0,    0, 8'h00, 0, 8'h00, 0, "R8 ion and iof");
    step(1, ioWord(7),   0, 8'h00, 0, 8'h00, 0, "R8 ion again");
    step(0, 16'h0,       0, 8'h00, 0, 8'h00, 1, "R9 taken");
    step(1, 16'h7FC0,    0, 8'h00, 0, 8'hFF, 0, "R11 I bit clear");
    step(1, 16'hBFC0,    0, 8'h00, 0, 8'hFF, 0, "R11 opcode 3");
    step(0, 16'hFFC0,    0, 8'h00, 0, 8'hFF, 0, "R11 exe low");
    step(0, 16'h0,       1, 8'h11, 0, 8'h00, 0, "R2 capture again");
    step(1, ioWord(11),  1, 8'h22, 0, 8'h00, 0, "R4 inp beats busy strobe");
    step(1, ioWord(11),  1, 8'h33, 0, 8'h00, 0, "R2 strobe lost to inp");
    step(1, ioWord(10),  0, 8'h00, 0, 8'h77, 0, "R5 out again");
    step(1, ioWord(10),  0, 8'h00, 1, 8'h88, 0, "R5 out beats ack");
    step(0, 16'h0,       0, 8'h00, 0, 8'h00, 0, "R5 after collision");
    step(1, 16'hF300,    0, 8'h00, 0, 8'h00, 0, "R7 both skips");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:12] = 4'hF;
      step(($urandom % 5) != 0, w, ($urandom % 3) == 0, 8'($urandom),
           ($urandom % 3) == 0, 8'($urandom), ($urandom % 9) == 0, "R11 random");
    end

    summary();
    $finish;
  end
endmodule